// File: doc/BRIEF.md
# Wake-on-LAN Magic Packet Detector

This block watches a received Ethernet frame as it arrives one byte at a time and decides whether the frame is a magic packet addressed to this station. A magic packet carries a synchronisation run of `0xFF` bytes, followed by sixteen back-to-back copies of the station's 48-bit MAC address. The pattern may sit anywhere in the frame, for example after the header fields or at the very first byte. The receive path drives the byte stream with start-of-frame and end-of-frame markers and a valid qualifier. In the end-of-frame cycle it also gives a flag that says whether the frame check sequence was good.

Whether detection is armed depends on a power-state input. In full power, detection is armed only while the magic-packet enable is set. In the low-power state, detection is armed whatever the enable is. In the deeper states it is never armed. When a frame that contains the pattern ends with a good check sequence and detection is armed, the block raises a one-cycle wake pulse. It also sets a sticky flag, which the host clears with a write-one pulse.

Top module: `magic_pkt_detect`

## Requirements
- R1: A sync run of six or more consecutive `0xFF` bytes is accepted. A run of five or fewer does not arm the address match. The first address copy starts at the first byte of the run that is not `0xFF`, so a station address whose first byte is `0xFF` can never match.
- R2: After the sync run, the station address must appear exactly 16 times in a row with no foreign byte between the copies. Each copy is sent most-significant byte of `station_mac_i` first. Fifteen copies do not match.
- R3: The pattern is found at any byte offset in the frame, including offset 0 and after the header bytes. Bytes that follow a complete pattern, such as the check sequence, do not undo the match.
- R4: A byte that breaks an address copy returns the block to hunting for sync. If that byte is `0xFF`, it counts as the first byte of a new sync run.
- R5: Every valid byte marked with `sof_i` clears all match progress from earlier frames. That byte is then processed as the first byte of the new frame.
- R6: A matching frame whose `crc_ok_i` is low in its end-of-frame cycle produces no wake.
- R7: The state of the detection gate in the end-of-frame cycle decides whether a wake can occur. `pwr_state_i` encoding: `2'b00` = full power, where detection is armed only if `mp_enable_i` = 1. `2'b01` = low power, where detection is always armed. `2'b10` and `2'b11` = deeper states, where detection is never armed.
- R8: `wake_o` is high for exactly one cycle. That cycle is the one after the clock edge that accepts the end-of-frame byte.
- R9: `wake_sticky_o` rises together with `wake_o` and holds until a cycle with `wake_clr_i` = 1, after which it reads 0. If a wake and a clear fall in the same cycle, the wake wins.
- R10: Cycles with `byte_valid_i` low are ignored and do not break a sync run or an address copy. `sof_i` and `eof_i` count only when `byte_valid_i` is high.
- R11: After reset, `wake_o` and `wake_sticky_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sof_i | input | 1 | Current byte is the first of a frame |
| byte_valid_i | input | 1 | `byte_i` holds a frame byte this cycle |
| byte_i | input | 8 | Received frame byte |
| eof_i | input | 1 | Current byte is the last of a frame |
| crc_ok_i | input | 1 | Frame check sequence good, sampled with the end-of-frame byte |
| station_mac_i | input | 48 | Station MAC address, bits 47:40 sent first |
| pwr_state_i | input | 2 | Power state: 00 full, 01 low, 10/11 deeper |
| mp_enable_i | input | 1 | Magic-packet enable, used in full power |
| wake_clr_i | input | 1 | Write-one pulse that clears the sticky flag |
| wake_o | output | 1 | One-cycle wake pulse |
| wake_sticky_o | output | 1 | Sticky wake status |

## Verification
The assertions check several rules on every cycle:
- a wake pulse can come only from an accepted end-of-frame byte with a good check sequence, and only while the detection gate is armed;
- the sticky flag follows its set, hold and clear rules;
- the sync counter empties on any byte that is not `0xFF`;
- a completed match survives until the next start of frame;
- the address match is entered only from a full sync run.

Whether a given byte sequence counts as a magic packet can only be shown by the bench's frames. Those frames cover long and short sync runs, fifteen versus sixteen copies, a broken copy that restarts sync on `0xFF`, progress carried across a frame boundary, valid gaps, and the power-state table.

// File: rtl/magic_pkg.sv
package magic_pkg;
  typedef enum logic [1:0] {
    MS_HUNT  = 2'd0,
    MS_REP   = 2'd1,
    MS_FOUND = 2'd2
  } match_state_e;

  localparam logic [1:0] PWR_FULL = 2'b00;
  localparam logic [1:0] PWR_LOW  = 2'b01;
  localparam logic [7:0] SYNC_BYTE = 8'hFF;
endpackage

// File: rtl/magic_sync_counter.sv
module magic_sync_counter #(
  parameter int unsigned SYNC_LEN = 6
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  input  logic sof_i,
  input  logic is_ff_i,
  input  logic restart_i,
  output logic sync_ok_o
);
  localparam int unsigned CNT_W = $clog2(SYNC_LEN + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(SYNC_LEN);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (step_i) begin
      if (sof_i)          cnt_q <= is_ff_i ? CNT_W'(1) : '0;
      else if (restart_i) cnt_q <= '0;
      else if (is_ff_i)   cnt_q <= (cnt_q == CNT_MAX) ? cnt_q : cnt_q + CNT_W'(1);
      else                cnt_q <= '0;
    end
  end

  // saturating: a longer run still reads as complete
  assign sync_ok_o = (cnt_q == CNT_MAX);

  // R4
  sync_break_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && !sof_i && !is_ff_i) |=> (cnt_q == '0));

  // R1
  sync_sat_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_MAX);

  // R10
  sync_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> $stable(cnt_q));
endmodule

// File: rtl/magic_addr_tracker.sv
module magic_addr_tracker
  import magic_pkg::*;
#(
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned REPS       = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    step_i,
  input  logic                    sof_i,
  input  logic [7:0]              byte_i,
  input  logic                    is_ff_i,
  input  logic                    sync_ok_i,
  input  logic [8*ADDR_BYTES-1:0] mac_i,
  output logic                    restart_o,
  output logic                    matched_o
);
  localparam int unsigned POS_W = $clog2(ADDR_BYTES);
  localparam int unsigned REP_W = $clog2(REPS);
  localparam logic [POS_W-1:0] POS_LAST = POS_W'(ADDR_BYTES - 1);
  localparam logic [REP_W-1:0] REP_LAST = REP_W'(REPS - 1);

  logic [7:0] mac_bytes [ADDR_BYTES];

  for (genvar g = 0; g < ADDR_BYTES; g++) begin : g_mac
    assign mac_bytes[g] = mac_i[8*(ADDR_BYTES-1-g) +: 8];
  end

  match_state_e     state_q, state_d;
  logic [POS_W-1:0] pos_q, pos_d;
  logic [REP_W-1:0] rep_q, rep_d;
  logic             complete;
  logic             byte_hit;
  logic             entry_hit;

  always_comb begin
    byte_hit  = (byte_i == mac_bytes[pos_q]);
    entry_hit = sync_ok_i && !is_ff_i && (byte_i == mac_bytes[0]);
    state_d   = state_q;
    pos_d     = pos_q;
    rep_d     = rep_q;
    complete  = 1'b0;
    restart_o = 1'b0;
    if (step_i) begin
      if (sof_i) begin
        state_d = MS_HUNT;
        pos_d   = '0;
        rep_d   = '0;
      end else begin
        unique case (state_q)
          MS_HUNT: begin
            if (entry_hit) begin
              state_d = MS_REP;
              pos_d   = POS_W'(1);
              rep_d   = '0;
            end
          end
          MS_REP: begin
            if (byte_hit) begin
              restart_o = 1'b1;
              if (pos_q == POS_LAST) begin
                pos_d = '0;
                if (rep_q == REP_LAST) begin
                  state_d  = MS_FOUND;
                  complete = 1'b1;
                end else begin
                  rep_d = rep_q + REP_W'(1);
                end
              end else begin
                pos_d = pos_q + POS_W'(1);
              end
            end else begin
              // break: back to hunting, counter sees this byte fresh
              state_d = MS_HUNT;
              pos_d   = '0;
              rep_d   = '0;
            end
          end
          MS_FOUND: restart_o = 1'b1;
          default:  state_d = MS_HUNT;
        endcase
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MS_HUNT;
      pos_q   <= '0;
      rep_q   <= '0;
    end else begin
      state_q <= state_d;
      pos_q   <= pos_d;
      rep_q   <= rep_d;
    end
  end

  assign matched_o = (state_q == MS_FOUND) || complete;

  // R3
  found_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == MS_FOUND && !(step_i && sof_i)) |=> (state_q == MS_FOUND));

  // R5
  sof_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (step_i && sof_i) |=> (state_q == MS_HUNT));

  // R1
  rep_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == MS_REP && $past(state_q) == MS_HUNT)
      |-> $past(sync_ok_i && step_i && byte_i != SYNC_BYTE));

  // R10
  track_gap_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !step_i |=> ($stable(state_q) && $stable(pos_q) && $stable(rep_q)));
endmodule

// File: rtl/magic_wake_ctrl.sv
module magic_wake_ctrl
  import magic_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       step_i,
  input  logic       eof_i,
  input  logic       crc_ok_i,
  input  logic       matched_i,
  input  logic [1:0] pwr_state_i,
  input  logic       mp_enable_i,
  input  logic       wake_clr_i,
  output logic       wake_o,
  output logic       wake_sticky_o
);
  logic det_en;
  logic fire;
  logic wake_q, sticky_q;

  always_comb begin
    unique case (pwr_state_i)
      PWR_FULL: det_en = mp_enable_i;
      PWR_LOW:  det_en = 1'b1;
      default:  det_en = 1'b0;
    endcase
  end

  assign fire = step_i && eof_i && crc_ok_i && matched_i && det_en;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wake_q   <= 1'b0;
      sticky_q <= 1'b0;
    end else begin
      wake_q   <= fire;
      sticky_q <= fire || (sticky_q && !wake_clr_i);
    end
  end

  assign wake_o        = wake_q;
  assign wake_sticky_o = sticky_q;

  // R6
  wake_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(step_i && eof_i && crc_ok_i));

  // R7
  wake_gate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> (($past(pwr_state_i) == PWR_FULL && $past(mp_enable_i)) ||
                $past(pwr_state_i) == PWR_LOW));

  // R9
  sticky_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> wake_sticky_o);

  // R9
  sticky_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wake_sticky_o && !wake_clr_i) |=> wake_sticky_o);

  // R9
  sticky_clr_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_clr_i |=> (wake_sticky_o == wake_o));
endmodule

// File: rtl/magic_pkt_detect.sv
module magic_pkt_detect
  import magic_pkg::*;
#(
  parameter int unsigned SYNC_LEN   = 6,
  parameter int unsigned ADDR_BYTES = 6,
  parameter int unsigned REPS       = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    sof_i,
  input  logic                    byte_valid_i,
  input  logic [7:0]              byte_i,
  input  logic                    eof_i,
  input  logic                    crc_ok_i,
  input  logic [8*ADDR_BYTES-1:0] station_mac_i,
  input  logic [1:0]              pwr_state_i,
  input  logic                    mp_enable_i,
  input  logic                    wake_clr_i,
  output logic                    wake_o,
  output logic                    wake_sticky_o
);
  logic is_ff;
  logic sync_ok;
  logic restart;
  logic matched;

  assign is_ff = (byte_i == SYNC_BYTE);

  magic_sync_counter #(.SYNC_LEN(SYNC_LEN)) u_sync (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (byte_valid_i),
    .sof_i     (sof_i),
    .is_ff_i   (is_ff),
    .restart_i (restart),
    .sync_ok_o (sync_ok)
  );

  magic_addr_tracker #(.ADDR_BYTES(ADDR_BYTES), .REPS(REPS)) u_track (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .step_i    (byte_valid_i),
    .sof_i     (sof_i),
    .byte_i    (byte_i),
    .is_ff_i   (is_ff),
    .sync_ok_i (sync_ok),
    .mac_i     (station_mac_i),
    .restart_o (restart),
    .matched_o (matched)
  );

  magic_wake_ctrl u_wake (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .step_i        (byte_valid_i),
    .eof_i         (eof_i),
    .crc_ok_i      (crc_ok_i),
    .matched_i     (matched),
    .pwr_state_i   (pwr_state_i),
    .mp_enable_i   (mp_enable_i),
    .wake_clr_i    (wake_clr_i),
    .wake_o        (wake_o),
    .wake_sticky_o (wake_sticky_o)
  );

  // R8
  wake_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wake_o |-> $past(byte_valid_i && eof_i));
endmodule

// File: tb/tb_magic_pkt_detect.sv
module tb_magic_pkt_detect;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        sof_i = 1'b0, byte_valid_i = 1'b0, eof_i = 1'b0, crc_ok_i = 1'b0;
  logic [7:0]  byte_i = 8'h00;
  logic [47:0] station_mac_i = 48'h02_1A_3C_FF_5E_6F;
  logic [1:0]  pwr_state_i = 2'b00;
  logic        mp_enable_i = 1'b1;
  logic        wake_clr_i = 1'b0;
  logic        wake_o, wake_sticky_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  logic [7:0] frm[$];
  logic got_wake, got_next;

  magic_pkt_detect dut (
    .clk_i(clk_i), .rst_ni(rst_ni), .sof_i(sof_i), .byte_valid_i(byte_valid_i),
    .byte_i(byte_i), .eof_i(eof_i), .crc_ok_i(crc_ok_i),
    .station_mac_i(station_mac_i), .pwr_state_i(pwr_state_i),
    .mp_enable_i(mp_enable_i), .wake_clr_i(wake_clr_i),
    .wake_o(wake_o), .wake_sticky_o(wake_sticky_o)
  );

  always #5 clk_i = ~clk_i;

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == 150000) begin
      failures++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic push_ff(input int n);
    for (int i = 0; i < n; i++) frm.push_back(8'hFF);
  endtask

  task automatic push_mac(input int n);
    for (int r = 0; r < n; r++)
      for (int k = 0; k < 6; k++) frm.push_back(station_mac_i[8*(5-k) +: 8]);
  endtask

  task automatic push_hdr();
    push_mac(1);
    for (int k = 0; k < 6; k++) frm.push_back(8'h10 + 8'(k));
    frm.push_back(8'h08);
    frm.push_back(8'h42);
  endtask

  task automatic push_crc();
    frm.push_back(8'hA5); frm.push_back(8'h5A);
    frm.push_back(8'h3C); frm.push_back(8'hC3);
  endtask

  // send frm; got_wake sampled one edge after eof byte, got_next one later
  task automatic send_frame(input logic crc, input logic gaps, input logic clr_at_eof);
    for (int i = 0; i < frm.size(); i++) begin
      if (gaps && (i % 3 == 1)) begin
        @(negedge clk_i);
        byte_valid_i = 1'b0; sof_i = 1'b0; eof_i = 1'b0; byte_i = 8'hFF;
      end
      @(negedge clk_i);
      byte_valid_i = 1'b1;
      byte_i = frm[i];
      sof_i  = (i == 0);
      eof_i  = (i == frm.size() - 1);
      crc_ok_i = crc;
      wake_clr_i = clr_at_eof && (i == frm.size() - 1);
    end
    @(negedge clk_i);
    byte_valid_i = 1'b0; sof_i = 1'b0; eof_i = 1'b0; wake_clr_i = 1'b0;
    got_wake = wake_o;
    @(negedge clk_i);
    got_next = wake_o;
    frm.delete();
  endtask

  task automatic clear_sticky();
    @(negedge clk_i); wake_clr_i = 1'b1;
    @(negedge clk_i); wake_clr_i = 1'b0;
  endtask

  task automatic t_reset();
    check("R11 wake after reset", int'(wake_o), 0);
    check("R11 sticky after reset", int'(wake_sticky_o), 0);
  endtask

  task automatic t_basic();
    push_hdr(); push_ff(6); push_mac(16); push_crc();
    send_frame(1'b1, 1'b0, 1'b0);
    check("R2 sixteen copies wake", int'(got_wake), 1);
    check("R8 pulse one cycle", int'(got_next), 0);
    check("R9 sticky set", int'(wake_sticky_o), 1);
    repeat (3) @(negedge clk_i);
    check("R9 sticky held", int'(wake_sticky_o), 1);
    clear_sticky();
    check("R9 sticky cleared", int'(wake_sticky_o), 0);
  endtask

  task automatic t_offset0();
    push_ff(6); push_mac(16); push_crc();
    send_frame(1'b1, 1'b0, 1'b0);
    check("R3 pattern at offset 0", int'(got_wake), 1);
    clear_sticky();
  endtask

  task automatic t_sync_len();
    push_hdr(); push_ff(9); push_mac(16); push_crc();
    send_frame(1'b1, 1'b0, 1'b0);
    check("R1 long sync accepted", int'(got_wake), 1);
    clear_sticky();
    push_hdr(); push_ff(5); push_mac(16); push_crc();
    send_frame(1'b1, 1'b0, 1'b0);
    check("R1 five ff rejected", int'(got_wake), 0);
    check("R1 no sticky on short sync", int'(wake_sticky_o), 0);
  endtask

  task automatic t_fifteen();
    push_hdr(); push_ff(6); push_mac(15); push_crc();
    send_frame(1'b1, 1'b0, 1'b0);
    check("R2 fifteen copies rejected", int'(got_wake), 0);
  endtask

  task automatic t_break();
    push_hdr(); push_ff(6); push_mac(3); push_ff(6); push_mac(16); push_crc();
    send_frame(1'b1, 1'b0, 1'b0);
    check("R4 breaking ff starts new sync", int'(got_wake), 1);
    clear_sticky();
    push_hdr(); push_ff(6); push_mac(3); push_ff(5); push_mac(16); push_crc();
    send_frame(1'b1, 1'b0, 1'b0);
    check("R4 five ff after break rejected", int'(got_wake), 0);
    push_hdr(); push_ff(6); push_mac(2); frm.push_back(8'h77);
    push_mac(14); push_crc();
    send_frame(1'b1, 1'b0, 1'b0);
    check("R4 foreign byte breaks copies", int'(got_wake), 0);
  endtask

  task automatic t_sof_clear();
    push_hdr(); push_ff(6); push_mac(8);
    send_frame(1'b1, 1'b0, 1'b0);
    check("R5 partial frame no wake", int'(got_wake), 0);
    push_mac(8); push_crc();
    send_frame(1'b1, 1'b0, 1'b0);
    check("R5 progress cleared at sof", int'(got_wake), 0);
  endtask

  task automatic t_crc();
    push_hdr(); push_ff(6); push_mac(16); push_crc();
    send_frame(1'b0, 1'b0, 1'b0);
    check("R6 bad crc ignored", int'(got_wake), 0);
    check("R6 no sticky on bad crc", int'(wake_sticky_o), 0);
  endtask

  task automatic t_power(input logic [1:0] ps, input logic en, input int exp);
    pwr_state_i = ps; mp_enable_i = en;
    push_hdr(); push_ff(6); push_mac(16); push_crc();
    send_frame(1'b1, 1'b0, 1'b0);
    check($sformatf("R7 pwr=%0d en=%0d", ps, en), int'(got_wake), exp);
    clear_sticky();
  endtask

  task automatic t_gaps();
    pwr_state_i = 2'b00; mp_enable_i = 1'b1;
    push_hdr(); push_ff(6); push_mac(16); push_crc();
    send_frame(1'b1, 1'b1, 1'b0);
    check("R10 valid gaps ignored", int'(got_wake), 1);
  endtask

  task automatic t_set_wins();
    push_hdr(); push_ff(6); push_mac(16); push_crc();
    send_frame(1'b1, 1'b0, 1'b1);
    check("R9 set wins over clear", int'(wake_sticky_o), 1);
    clear_sticky();
    check("R9 cleared after set-wins", int'(wake_sticky_o), 0);
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (2) @(negedge clk_i);
    t_reset();
    t_basic();
    t_offset0();
    t_sync_len();
    t_fifteen();
    t_break();
    t_sof_clear();
    t_crc();
    t_power(2'b00, 1'b0, 0);
    t_power(2'b00, 1'b1, 1);
    t_power(2'b01, 1'b0, 1);
    t_power(2'b01, 1'b1, 1);
    t_power(2'b10, 1'b1, 0);
    t_power(2'b11, 1'b1, 0);
    t_gaps();
    t_set_wins();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule